// File: doc/BRIEF.md
# Inhibit-Based Read Sequencer

This block reads the parallel position word of a tracking angle converter without looking at the converter's busy flag. A one-cycle read request from the host side makes the block drive an active-low read strobe that is aligned to the system clock. A registered copy of that strobe, one clock later, drives the converter's combined active-low inhibit and output-enable line. The converter's counter stays frozen for as long as that line is low.

The position word is latched on the falling clock edge that follows the strobe's rising edge. At that point the strobe has already been released, but inhibit is still held low. So the word is taken half a cycle after the strobe transition and before the converter can start updating again. The latched word and a one-cycle ready pulse appear on the next rising edge.

The strobe width is a parameter in clock cycles. With the default of 12 cycles at a 10 MHz clock, the strobe lasts 1.2 us and inhibit lasts at least 400 ns. A request that arrives while a read is in progress is remembered and served once the current read has finished.

Top module: `inhibit_read_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rdN and inhEnN are 1, dataValid is 0 and posOut is all zeros.
- R2: When the block is idle, a request sampled high on a rising clock edge drives rdN to 0 on that same edge.
- R3: Each read holds rdN at 0 for exactly MIN_RD_CYC clock cycles.
- R4: inhEnN equals the value rdN had one clock cycle earlier, so it falls one cycle after rdN falls and rises one cycle after rdN rises.
- R5: posOut reports the word present on posIn while inhEnN is low. That word is sampled on the falling clock edge when rdN is already 1 and inhEnN is still 0.
- R6: dataValid is a one-cycle pulse on the same rising edge on which inhEnN returns to 1. Between pulses, posOut does not change.
- R7: Any number of requests that arrive while a read is active produce exactly one further read after the active one ends.
- R8: rdN stays at 1 for at least two clock cycles between reads. A pending follow-up read starts after exactly two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10 MHz |
| rstN | input | 1 | Asynchronous active-low reset |
| readReq | input | 1 | Host read request, sampled on rising edges |
| posIn | input | POS_W | Parallel position word from the converter |
| rdN | output | 1 | Clock-aligned active-low read strobe |
| inhEnN | output | 1 | Active-low combined inhibit and output enable to the converter |
| posOut | output | POS_W | Most recently captured position word |
| dataValid | output | 1 | One-cycle pulse marking a new posOut |

## Verification
The assertions assume that posIn changes only on rising clock edges and stays frozen while inhEnN is low. This is how the converter behaves when it is inhibited. The bench models the converter as a counter that advances by a random step on every rising edge while inhEnN is high. That model keeps the stimulus inside the assumption. It also makes any capture taken after inhibit is released return a different word. Requests are driven on falling edges as random bursts and gaps, some of which land inside an active read. A few directed sequences pin down the start edge and the collapsing of pending requests.

// File: rtl/inhibit_read_seq_pkg.sv
package inhibit_read_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_RECOV = 2'd2
  } seqState_t;

  typedef struct packed {
    logic rdN;      // strobe level as driven to the pin
    logic capture;  // arm the falling-edge word latch
    logic present;  // publish the latched word on the next rising edge
  } rdCtl_t;
endpackage

// File: rtl/inhibit_read_ctrl.sv
module inhibit_read_ctrl
  import inhibit_read_seq_pkg::*;
#(
  parameter int MIN_RD_CYC = 12
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   readReq,
  output rdCtl_t ctl
);
  localparam int CNT_W = $clog2(MIN_RD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_RD_CYC);

  seqState_t state;
  logic [CNT_W-1:0] lowCnt;
  logic rdNReg;
  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lowCnt  <= '0;
      rdNReg  <= 1'b1;
      pending <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (readReq || pending) begin
            state   <= ST_LOW;
            rdNReg  <= 1'b0;
            lowCnt  <= CNT_W'(1);
            pending <= 1'b0;
          end
        end
        ST_LOW: begin
          if (readReq) pending <= 1'b1;
          if (lowCnt == CNT_LAST) begin
            rdNReg <= 1'b1;
            state  <= ST_RECOV;
          end else begin
            lowCnt <= lowCnt + CNT_W'(1);
          end
        end
        ST_RECOV: begin
          if (readReq) pending <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.rdN     = rdNReg;
    ctl.capture = (state == ST_RECOV);
    ctl.present = (state == ST_RECOV);
  end

  // Independent observation counters for the strobe timing checks.
  logic [CNT_W-1:0] obsLow;
  logic [1:0] obsHigh;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obsLow  <= '0;
      obsHigh <= 2'd2;
    end else begin
      obsLow  <= rdNReg ? '0 : obsLow + CNT_W'(1);
      obsHigh <= !rdNReg ? 2'd0 : (obsHigh == 2'd2 ? 2'd2 : obsHigh + 2'd1);
    end
  end

  a_r3_low_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.rdN) |-> obsLow == CNT_LAST);

  a_r8_high_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.rdN) |-> obsHigh == 2'd2);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && state != ST_IDLE) |=> (pending || state == ST_LOW));
endmodule

// File: rtl/inhibit_read_dp.sv
module inhibit_read_dp
  import inhibit_read_seq_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdCtl_t           ctl,
  input  logic [POS_W-1:0] posIn,
  output logic             inhEnN,
  output logic [POS_W-1:0] posOut,
  output logic             dataValid
);
  logic [POS_W-1:0] capWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inhEnN <= 1'b1;
    else       inhEnN <= ctl.rdN;
  end

  // Opposite-edge latch: taken half a cycle after the strobe rises.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)            capWord <= '0;
    else if (ctl.capture) capWord <= posIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posOut    <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= ctl.present;
      if (ctl.present) posOut <= capWord;
    end
  end

  a_r4_inh_falls_late: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.rdN) |=> $fell(inhEnN));

  a_r5_cap_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> (ctl.rdN && !inhEnN));

  a_r6_valid_on_release: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $rose(inhEnN));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(posOut));
endmodule

// File: rtl/inhibit_read_seq.sv
module inhibit_read_seq
  import inhibit_read_seq_pkg::*;
#(
  parameter int POS_W      = 16,
  parameter int MIN_RD_CYC = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             readReq,
  input  logic [POS_W-1:0] posIn,
  output logic             rdN,
  output logic             inhEnN,
  output logic [POS_W-1:0] posOut,
  output logic             dataValid
);
  rdCtl_t ctl;

  inhibit_read_ctrl #(.MIN_RD_CYC(MIN_RD_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .readReq(readReq), .ctl(ctl)
  );

  inhibit_read_dp #(.POS_W(POS_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .posIn(posIn),
    .inhEnN(inhEnN), .posOut(posOut), .dataValid(dataValid)
  );

  assign rdN = ctl.rdN;
endmodule

// File: tb/inhibit_read_seq_tb_top.sv
module inhibit_read_seq_tb_top;
  localparam int POS_W = 16;
  localparam int MIN   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readReq = 1'b0;
  logic [POS_W-1:0] posIn;
  logic rdN, inhEnN, dataValid;
  logic [POS_W-1:0] posOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  inhibit_read_seq #(.POS_W(POS_W), .MIN_RD_CYC(MIN)) dut_i (
    .clk(clk), .rstN(rstN), .readReq(readReq), .posIn(posIn),
    .rdN(rdN), .inhEnN(inhEnN), .posOut(posOut), .dataValid(dataValid)
  );

  always #10 clk = ~clk;

  // Converter model: a counter that freezes while inhibited.
  logic [POS_W-1:0] convCnt;
  logic [POS_W-1:0] step = 16'd1;
  always @(posedge clk) begin
    if (!rstN)       convCnt <= 16'h1234;
    else if (inhEnN) convCnt <= convCnt + step;
  end
  assign posIn = convCnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit gapOk(input int gap);
    return gap >= 2;
  endfunction

  // Monitor, sampled on falling edges.
  bit mon = 1'b0;
  logic prevRd = 1'b1, prevInh = 1'b1, prevValid = 1'b0;
  int lowRun = 0, highRun = 100, lastGap = 0;
  int falls = 0, valids = 0;
  logic [POS_W-1:0] expWord = '0, heldOut = '0;

  always @(negedge clk) begin
    if (mon) begin
      chk(inhEnN == prevRd, "R4 inhibit lag", int'(inhEnN), int'(prevRd));
      if (rdN && !prevRd) chk(lowRun == MIN, "R3 strobe width", lowRun, MIN);
      if (!rdN && prevRd) begin
        falls++;
        lastGap = highRun;
        chk(gapOk(highRun), "R8 gap", highRun, 2);
      end
      if (!inhEnN && prevInh) expWord = convCnt;
      if (dataValid) begin
        valids++;
        chk(posOut == expWord, "R5 captured word", int'(posOut), int'(expWord));
        chk(inhEnN && !prevInh, "R6 valid on release", int'(inhEnN), 1);
        heldOut = posOut;
      end else begin
        chk(posOut == heldOut, "R6 output held", int'(posOut), int'(heldOut));
      end
      if (prevValid) chk(!dataValid, "R6 single pulse", int'(dataValid), 0);
      if (rdN) begin
        highRun = prevRd ? highRun + 1 : 1;
        lowRun = 0;
      end else begin
        lowRun = prevRd ? 1 : lowRun + 1;
      end
      prevRd = rdN;
      prevInh = inhEnN;
      prevValid = dataValid;
    end
    step <= POS_W'($urandom_range(1, 7));
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseReq(input int len);
    readReq = 1'b1;
    waitN(len);
    readReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int seedDummy;
    int f0;
    seedDummy = $urandom(32'd2718);
    waitN(2);
    chk(rdN && inhEnN, "R1 reset pins", int'({rdN, inhEnN}), 3);
    chk(!dataValid && posOut == '0, "R1 reset outputs", int'(posOut), 0);
    waitN(3);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdN && inhEnN && !dataValid && posOut == '0, "R1 after release",
        int'({rdN, inhEnN, dataValid}), 6);
    mon = 1'b1;
    waitN(4);

    // R2: idle start on the sampling edge.
    pulseReq(1);
    chk(!rdN, "R2 start edge", int'(rdN), 0);
    waitN(MIN + 6);
    chk(valids == 1, "R6 first read delivered", valids, 1);

    // R7: several requests during one read collapse into one follow-up read.
    f0 = falls;
    pulseReq(1);
    waitN(2);
    pulseReq(1);
    waitN(2);
    pulseReq(2);
    waitN(3 * MIN);
    chk(falls - f0 == 2, "R7 collapse", falls - f0, 2);
    chk(lastGap == 2, "R8 back-to-back gap", lastGap, 2);

    // Random bursts and gaps.
    for (int i = 0; i < 80; i++) begin
      pulseReq($urandom_range(1, 3));
      waitN($urandom_range(0, 30));
    end
    waitN(3 * MIN + 10);
    chk(falls == valids, "R5 one word per read", valids, falls);
    chk(rdN && inhEnN, "R7 all requests served", int'({rdN, inhEnN}), 3);
    finishRun();
  end
endmodule